// File: doc/BRIEF.md
# Multiplexed ADC Serial Readout Controller

This block sits on the host side of a sleeping, multi-channel serial converter and runs its four-wire link: chip select (active low), serial clock, host-to-converter data and converter-to-host data. Each pass starts with a cheap poll. The block lowers chip select, waits one half-period of the serial clock, and looks at the first bit the converter offers. That bit is an active-low end-of-conversion flag. If it reads high, chip select goes back up before any clock edge, so the converter returns to sleep with its held result untouched. The block then waits a programmable interval and tries again.

When the flag reads low, the block clocks out a whole frame. In the same frame it shifts in the channel-selection word that the converter will use for its next conversion. It can add padding clocks so that the frame is 24 or 32 clocks long, and it throws away the padding bits. When chip select rises at the end of a frame, the block posts the result on a parallel port with a one-cycle strobe. The result carries the raw sign bit, the 16 data bits and a two's complement view. It also carries the selection word that was in force for that conversion, which is the word sent one completed frame earlier. The first result after reset is marked as having an unknown channel.

Top module: `adc_mux_reader`

## Requirements
- R1: While reset is high, and in the first cycle after it, chip select is high, the serial clock and host data are low, and the result strobe is low.
- R2: With `run` high and the block idle, chip select falls. It then stays low with the clock low for exactly H cycles before the first rising clock edge, where H is `cfg_half` (0 is treated as 1).
- R3: If the converter data line is 1 after that setup time, chip select rises with no clock pulse at all and no result is posted. Chip select then stays high for G+1 cycles before the next fall, where G is `cfg_gap` (0 is treated as 1).
- R4: The serial clock idles low, is only high while chip select is low, and alternates H cycles high and H cycles low.
- R5: A read frame has exactly 19, 24 or 32 rising clock edges for `cfg_frame` values 0, 1 and 2 or 3. Chip select rises H cycles after the last falling edge.
- R6: Converter data is sampled at each rising clock edge. The first 19 samples are, in order, the flag, a fixed zero, the sign bit and 16 data bits most significant first. All later samples are discarded.
- R7: Host data carries the selection word bits 5 down to 0 (enable, single-ended, odd/sign, address bits 2..0). Bit 5 is presented from the chip-select fall and at rising edge 1, and bit 6-k at rising edge k for k up to 6. After that it is 0. It changes only while the clock is low.
- R8: After a complete frame, `res_valid` is high for exactly one cycle, the same cycle chip select rises. In that cycle `res_sign` is the sign bit, `res_data` the 16 data bits, and `res_value` is {~sign, data}.
- R9: `res_chan` is the selection word sent in the previous completed frame. `res_chan_unk` is 1 only for the first result after reset. Aborted polls change neither.
- R10: `next_sel` is sampled in the cycle chip select falls. Later changes do not affect the word sent in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Allow polling and reading |
| cfg_half | input | HALF_W | Serial clock half-period in system cycles |
| cfg_gap | input | GAP_W | Cycles to wait after chip select rises |
| cfg_frame | input | 2 | Frame length select: 0 = 19, 1 = 24, else 32 clocks |
| next_sel | input | 6 | Selection word for the next conversion |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_sck | output | 1 | Serial clock |
| adc_sdi | output | 1 | Host-to-converter data |
| adc_sdo | input | 1 | Converter-to-host data |
| res_valid | output | 1 | One-cycle result strobe |
| res_sign | output | 1 | Raw sign bit |
| res_data | output | 16 | Raw data bits |
| res_value | output | 17 | Two's complement view of the result |
| res_chan | output | 6 | Selection word in force for this result |
| res_chan_unk | output | 1 | Channel unknown (first result after reset) |

## Verification
Three things happen on the same clock edge at the end of a frame: the result strobe is posted, chip select is released, and the selection word just sent moves into the tag slot. The channel tag that goes out must therefore be the older word. The bench mixes completed frames with aborted polls so that a wrong tag rotation, for example one triggered by an abort or one made a frame late, shows up in the tagged result. A reference schedule compares chip select, clock, host data and strobe on every cycle, and checks the posted fields in the exact cycle chip select rises.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_GAP
  } rd_state_t;

  localparam int FRAME_W  = 19;
  localparam int DATA_W   = 16;
  localparam int SIGN_POS = 16;
  localparam int SEL_W    = 6;
  localparam int RISE_W   = 6;

  function automatic logic [RISE_W-1:0] rises_for(input logic [1:0] mode);
    case (mode)
      2'd0:    return RISE_W'(19);
      2'd1:    return RISE_W'(24);
      default: return RISE_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/adcrd_tick.sv
module adcrd_tick #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = (limit == '0) ? '0 : limit - CNT_W'(1);
  assign tick = en && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/adcrd_seq.sv
module adcrd_seq
  import adcrd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CNT_W-1:0]  half_lim,
  input  logic [CNT_W-1:0]  gap_lim,
  input  logic [RISE_W-1:0] nbits,
  input  logic              sdo,
  output logic              cs_n,
  output logic              sck,
  output logic              ld,
  output logic              rise,
  output logic              fall,
  output logic              clr,
  output logic              fin
);
  rd_state_t         st;
  logic [RISE_W-1:0] rises;
  logic              tick;
  logic              abort_p;
  logic              first_p;
  logic              more_p;

  adcrd_tick #(.CNT_W(CNT_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (st != ST_IDLE),
    .limit((st == ST_GAP) ? gap_lim : half_lim),
    .tick (tick)
  );

  assign ld      = (st == ST_IDLE) && run;
  assign abort_p = (st == ST_SETUP) && tick && sdo;
  assign first_p = (st == ST_SETUP) && tick && !sdo;
  assign more_p  = (st == ST_LOW) && tick && (rises != nbits);
  assign fin     = (st == ST_LOW) && tick && (rises == nbits);
  assign fall    = (st == ST_HIGH) && tick;
  assign rise    = first_p || more_p;
  assign clr     = abort_p || fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cs_n  <= 1'b1;
      sck   <= 1'b0;
      rises <= '0;
    end else begin
      case (st)
        ST_IDLE: if (run) begin
          st    <= ST_SETUP;
          cs_n  <= 1'b0;
          rises <= '0;
        end
        ST_SETUP: if (tick) begin
          if (sdo) begin
            st   <= ST_GAP;
            cs_n <= 1'b1;
          end else begin
            st    <= ST_HIGH;
            sck   <= 1'b1;
            rises <= RISE_W'(1);
          end
        end
        ST_HIGH: if (tick) begin
          st  <= ST_LOW;
          sck <= 1'b0;
        end
        ST_LOW: if (tick) begin
          if (rises == nbits) begin
            st   <= ST_GAP;
            cs_n <= 1'b1;
          end else begin
            st    <= ST_HIGH;
            sck   <= 1'b1;
            rises <= rises + RISE_W'(1);
          end
        end
        ST_GAP: if (tick) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_ABORT_NO_CLOCK: assert property (@(posedge clk) disable iff (rst)
    abort_p |=> (cs_n && !sck)); // R3
  AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    sck |-> !cs_n); // R4
  AST_SETUP_BEFORE_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> !$past(cs_n)); // R2
endmodule

// File: rtl/adcrd_shift.sv
module adcrd_shift
  import adcrd_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                ld,
  input  logic [SEL_W-1:0]    sel_in,
  input  logic                rise,
  input  logic                fall,
  input  logic                clr,
  input  logic                sdo,
  output logic                sdi,
  output logic [SEL_W-1:0]    sent,
  output logic [SIGN_POS:0]   res_bits,
  output logic                flag_bit
);
  localparam int CN_W = $clog2(FRAME_W + 1);

  logic [SEL_W-1:0]   sel_sh;
  logic [FRAME_W-1:0] cap;
  logic [CN_W-1:0]    cap_n;
  logic               cap_full;

  assign cap_full = (cap_n == CN_W'(FRAME_W));
  assign sdi      = sel_sh[SEL_W-1];
  assign res_bits = cap[SIGN_POS:0];
  assign flag_bit = cap[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_sh <= '0;
      sent   <= '0;
    end else if (ld) begin
      sel_sh <= sel_in;
      sent   <= sel_in;
    end else if (clr) begin
      sel_sh <= '0;
    end else if (fall) begin
      sel_sh <= {sel_sh[SEL_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap   <= '0;
      cap_n <= '0;
    end else if (ld) begin
      cap_n <= '0;
    end else if (rise && !cap_full) begin
      cap   <= {cap[FRAME_W-2:0], sdo};
      cap_n <= cap_n + CN_W'(1);
    end
  end

  AST_PAD_DISCARDED: assert property (@(posedge clk) disable iff (rst)
    (rise && cap_full && !ld) |=> $stable(cap)); // R6
endmodule

// File: rtl/adc_mux_reader.sv
module adc_mux_reader
  import adcrd_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int GAP_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic [HALF_W-1:0]   cfg_half,
  input  logic [GAP_W-1:0]    cfg_gap,
  input  logic [1:0]          cfg_frame,
  input  logic [SEL_W-1:0]    next_sel,
  output logic                adc_cs_n,
  output logic                adc_sck,
  output logic                adc_sdi,
  input  logic                adc_sdo,
  output logic                res_valid,
  output logic                res_sign,
  output logic [DATA_W-1:0]   res_data,
  output logic [DATA_W:0]     res_value,
  output logic [SEL_W-1:0]    res_chan,
  output logic                res_chan_unk
);
  localparam int CNT_W = (GAP_W > HALF_W) ? GAP_W : HALF_W;

  logic              ld, rise, fall, clr, fin;
  logic [SEL_W-1:0]  sent;
  logic [SIGN_POS:0] bits;
  logic              flag_bit;
  logic [SEL_W-1:0]  prev_word;
  logic              prev_ok;

  adcrd_seq #(.CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .half_lim(CNT_W'(cfg_half)),
    .gap_lim (CNT_W'(cfg_gap)),
    .nbits   (rises_for(cfg_frame)),
    .sdo     (adc_sdo),
    .cs_n    (adc_cs_n),
    .sck     (adc_sck),
    .ld      (ld),
    .rise    (rise),
    .fall    (fall),
    .clr     (clr),
    .fin     (fin)
  );

  adcrd_shift u_shift (
    .clk     (clk),
    .rst     (rst),
    .ld      (ld),
    .sel_in  (next_sel),
    .rise    (rise),
    .fall    (fall),
    .clr     (clr),
    .sdo     (adc_sdo),
    .sdi     (adc_sdi),
    .sent    (sent),
    .res_bits(bits),
    .flag_bit(flag_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_sign     <= 1'b0;
      res_data     <= '0;
      res_value    <= '0;
      res_chan     <= '0;
      res_chan_unk <= 1'b1;
      prev_word    <= '0;
      prev_ok      <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (fin) begin
        res_valid    <= 1'b1;
        res_sign     <= bits[SIGN_POS];
        res_data     <= bits[DATA_W-1:0];
        res_value    <= {~bits[SIGN_POS], bits[DATA_W-1:0]};
        res_chan     <= prev_word;
        res_chan_unk <= !prev_ok;
        prev_word    <= sent;
        prev_ok      <= 1'b1;
      end
    end
  end

  AST_FRAME_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    fin |-> !flag_bit); // R3
  AST_SDI_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (adc_sck && $past(adc_sck)) |-> $stable(adc_sdi)); // R7
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R8
  AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (adc_cs_n && !$past(adc_cs_n))); // R8
endmodule

// File: tb/sim_adc_mux_reader.sv
`timescale 1ns/1ps
module sim_adc_mux_reader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b1;
  logic [7:0]  cfg_half = 8'd1;
  logic [15:0] cfg_gap = 16'd1;
  logic [1:0]  cfg_frame = 2'd0;
  logic [5:0]  next_sel = 6'd0;
  logic        adc_cs_n, adc_sck, adc_sdi;
  logic        adc_sdo = 1'b1;
  logic        res_valid, res_sign, res_chan_unk;
  logic [15:0] res_data;
  logic [16:0] res_value;
  logic [5:0]  res_chan;

  int checks = 0;
  int fails  = 0;

  // converter model state
  logic [31:0] adc_frame = 32'hFFFF_FFFF;
  logic        m_cs = 1'b1;
  logic        m_sck = 1'b0;
  int          m_idx = 0;
  int          m_rises = 0;
  logic [5:0]  m_rx = 6'd0;

  // reference history for the tag
  logic        have_prev = 1'b0;
  logic [5:0]  prev_word = 6'd0;

  always #4 clk = ~clk;

  adc_mux_reader u0 (
    .clk(clk), .rst(rst), .run(run), .cfg_half(cfg_half), .cfg_gap(cfg_gap),
    .cfg_frame(cfg_frame), .next_sel(next_sel), .adc_cs_n(adc_cs_n),
    .adc_sck(adc_sck), .adc_sdi(adc_sdi), .adc_sdo(adc_sdo),
    .res_valid(res_valid), .res_sign(res_sign), .res_data(res_data),
    .res_value(res_value), .res_chan(res_chan), .res_chan_unk(res_chan_unk)
  );

  // behavioural converter: data moves on falling clock, selection taken on rising
  always @(negedge clk) begin
    if (adc_cs_n) begin
      adc_sdo <= 1'b1;
      m_idx   <= 0;
    end else begin
      if (m_cs) begin
        adc_sdo <= adc_frame[31];
        m_rises <= 0;
        m_rx    <= 6'd0;
      end else begin
        if (m_sck && !adc_sck) begin
          if (m_idx < 31) adc_sdo <= adc_frame[30 - m_idx];
          else            adc_sdo <= 1'b1;
          m_idx <= m_idx + 1;
        end
        if (!m_sck && adc_sck) begin
          m_rises <= m_rises + 1;
          if (m_rises < 6) m_rx <= {m_rx[4:0], adc_sdi};
        end
      end
    end
    m_cs  <= adc_cs_n;
    m_sck <= adc_sck;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input string req, input logic cs, input logic sk,
                     input logic di, input logic v);
    @(negedge clk);
    chk(req, "cs_n", 32'(adc_cs_n), 32'(cs));
    chk("R4", "sck", 32'(adc_sck), 32'(sk));
    chk("R7", "sdi", 32'(adc_sdi), 32'(di));
    chk("R8", "valid", 32'(res_valid), 32'(v));
  endtask

  task automatic do_frame(input bit ready, input logic [5:0] word,
                          input logic sgn, input logic [15:0] data,
                          input int h, input int g, input logic [1:0] mode);
    int nb;
    logic [16:0] val;
    cfg_half  = 8'(h);
    cfg_gap   = 16'(g);
    cfg_frame = mode;
    next_sel  = word;
    adc_frame = {~ready, 1'b0, sgn, data, 13'h1FFF};
    nb = (mode == 2'd0) ? 19 : (mode == 2'd1) ? 24 : 32;
    for (int i = 0; i < h; i++) begin
      cyc("R2", 1'b0, 1'b0, word[5], 1'b0);
      if (i == 0) next_sel = ~word; // R10: late change must not leak
    end
    if (!ready) begin
      for (int i = 0; i < g; i++) cyc("R3", 1'b1, 1'b0, 1'b0, 1'b0);
      cyc("R3", 1'b1, 1'b0, 1'b0, 1'b0);
      return;
    end
    for (int k = 1; k <= nb; k++) begin
      for (int i = 0; i < h; i++)
        cyc("R5", 1'b0, 1'b1, (k <= 6) ? word[6-k] : 1'b0, 1'b0);
      for (int i = 0; i < h; i++)
        cyc("R5", 1'b0, 1'b0, (k < 6) ? word[5-k] : 1'b0, 1'b0);
    end
    cyc("R5", 1'b1, 1'b0, 1'b0, 1'b1);
    val = {~sgn, data};
    chk("R8", "sign", 32'(res_sign), 32'(sgn));
    chk("R6", "data", 32'(res_data), 32'(data));
    chk("R8", "value", 32'(res_value), 32'(val));
    chk("R9", "chan", 32'(res_chan), have_prev ? 32'(prev_word) : 32'(res_chan));
    chk("R9", "unk", 32'(res_chan_unk), 32'(!have_prev));
    chk("R10", "word seen by converter", 32'(m_rx), 32'(word));
    chk("R5", "rising edges", 32'(m_rises), 32'(nb));
    have_prev = 1'b1;
    prev_word = word;
    for (int i = 0; i < g - 1; i++) cyc("R3", 1'b1, 1'b0, 1'b0, 1'b0);
    cyc("R3", 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1", "cs_n", 32'(adc_cs_n), 32'd1);
      chk("R1", "sck", 32'(adc_sck), 32'd0);
      chk("R1", "sdi", 32'(adc_sdi), 32'd0);
      chk("R1", "valid", 32'(res_valid), 32'd0);
    end
    rst = 1'b0;
    do_frame(1'b1, 6'b101011, 1'b1, 16'hA5C3, 2, 3, 2'd0);
    do_frame(1'b0, 6'b111111, 1'b0, 16'h0000, 1, 2, 2'd0);
    do_frame(1'b1, 6'b100110, 1'b0, 16'h0001, 1, 1, 2'd1);
    do_frame(1'b1, 6'b110001, 1'b1, 16'hFFFF, 3, 2, 2'd2);
    do_frame(1'b0, 6'b010101, 1'b1, 16'h1234, 2, 4, 2'd2);
    do_frame(1'b1, 6'b000000, 1'b0, 16'h8000, 1, 5, 2'd3);
    do_frame(1'b1, 6'b111010, 1'b1, 16'h0000, 2, 1, 2'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not finish actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule